// File: doc/BRIEF.md
# Hidden Address-Latch Tracker

This block mirrors the 16-bit internal address latch that a classic 8-bit microprocessor keeps out of sight of software. The latch is never written directly. Many instructions leave a value in it as a side effect of computing a memory, port or branch address. The decoder in front of this block reduces each instruction to a 6-bit class code. When the instruction retires, the decoder pulses a completion strobe and presents the operand values that the rules may need: the program counter before and after, BC before and after, DE, HL, the index register in use, A, the immediate byte, word and signed displacement, the word taken from the stack, a condition-taken flag and a compare-match flag.

On the strobe, the block works out the new latch value for that class and registers it. Classes with no rule leave the latch as it was. The registered pointer is exposed directly. It is also exposed as an 8-bit flag fragment that places pointer bits 13 and 11 where a bit-test on (HL) would leak them into the flag register. The block has no decoding, ALU, memory or bus timing of its own.

Top module: `shadow_ptr_unit`

## Requirements
- R1: An active-low reset clears `ptr_o` to 0000h and `flag_bits_o` to 00h, and asserting reset during operation also returns `ptr_o` to 0000h.
- R2: `ptr_o` changes only in the clock after a cycle with `done_i` high. Class code 0, and any code from 36 to 63, leave it unchanged.
- R3: Class 1 (indexed memory access) loads `idx_i` plus `disp_i` sign-extended to 16 bits, wrapping modulo 65536.
- R4: Classes 2, 3 and 4 (A loaded from (BC), (DE) or an absolute word) and class 5 (16-bit load or store at an absolute word) load the full 16-bit address plus 1. The address is `bc_pre_i`, `de_i`, `imm16_i` and `imm16_i` respectively.
- R5: Classes 6, 7 and 8 (A stored to (BC), (DE) or an absolute word) and class 9 (A written to port n) load `acc_i` into the high byte. The low byte becomes the low address byte plus 1, modulo 256, with no carry into the high byte. For class 9 the low address byte is `imm8_i`.
- R6: Class 10 (A read from port n) loads `{acc_i, imm8_i} + 1` across all 16 bits. Class 11 (port access through C) loads `bc_pre_i + 1`.
- R7: Classes 12 and 13 (single compare, up or down) step the current pointer by +1 or -1. Classes 14 and 15 (repeating compare) load `pc_init_i + 1` when `bc_post_i` is nonzero and `match_i` is 0; otherwise they step by +1 or -1.
- R8: Class 16 (repeating block copy, either direction) loads `pc_init_i + 1` when `bc_post_i` is nonzero and otherwise leaves the pointer unchanged.
- R9: Classes 17 and 18 (single port input, up or down) load `bc_pre_i` plus or minus 1. Classes 21 and 22 (single port output) load `bc_post_i` plus or minus 1. The repeating forms 19, 20, 23 and 24 load `pc_init_i + 1` when `bc_post_i[15:8]` is nonzero and otherwise follow their single form.
- R10: Class 25 (absolute jump or call, conditional or not) loads `imm16_i`. Class 26 (relative jump) loads `pc_init_i + 2 + sext(disp_i)`. Class 27 applies the same value only when `cond_i` is 1. Class 28 (decrement-and-branch) applies it only when `bc_post_i[15:8]` is nonzero.
- R11: Class 29 (return of any kind) loads `stk_i`. Class 30 (conditional return) does so only when `cond_i` is 1. Class 31 (restart) loads `pc_new_i`.
- R12: Class 32 (16-bit add or subtract with carry on HL) and class 34 (nibble rotate through (HL)) load `hl_i + 1`. Class 33 (16-bit add on an index register) loads `idx_i + 1`. Class 35 (exchange with the stack top) loads `stk_i`.
- R13: `flag_bits_o[5]` equals `ptr_o[13]`, `flag_bits_o[3]` equals `ptr_o[11]`, and every other bit of `flag_bits_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| done_i | input | 1 | Instruction completion strobe |
| cls_i | input | 6 | Instruction class code |
| pc_init_i | input | 16 | Program counter at instruction start |
| pc_new_i | input | 16 | Program counter after execution |
| bc_pre_i | input | 16 | BC before execution |
| bc_post_i | input | 16 | BC after execution |
| de_i | input | 16 | DE |
| hl_i | input | 16 | HL before execution |
| idx_i | input | 16 | Index register before execution |
| acc_i | input | 8 | A before execution |
| imm8_i | input | 8 | Immediate byte |
| imm16_i | input | 16 | Immediate word |
| disp_i | input | 8 | Signed displacement |
| stk_i | input | 16 | Word popped or read from the stack |
| cond_i | input | 1 | Condition taken |
| match_i | input | 1 | Compare found A equal to memory |
| ptr_o | output | 16 | Registered hidden pointer |
| flag_bits_o | output | 8 | Pointer bits placed at their flag positions |

## Verification
The assertions watch, on every cycle, that the pointer holds without a completion strobe and for unlisted class codes. They also check that the flag fragment always tracks pointer bits 13 and 11, that the single compares step by exactly one, that a block copy ending with BC at zero keeps the pointer, and that an absolute jump lands on its word. Some behaviour can only be shown by the bench's scenarios because it depends on particular operand values: the 8-bit wrap of the store rules, the full-width carry of a port read, negative and positive displacements, and each branch of the repeat conditions with B or BC at zero and nonzero.

// File: rtl/shadow_ptr_pkg.sv
package shadow_ptr_pkg;

    localparam int CLS_W = 6;

    // Instruction classes presented by the decoder
    typedef enum logic [CLS_W-1:0] {
        K_NONE     = 6'd0,
        K_IDX_MEM  = 6'd1,
        K_LDA_BC   = 6'd2,
        K_LDA_DE   = 6'd3,
        K_LDA_NN   = 6'd4,
        K_LD16_NN  = 6'd5,
        K_STA_BC   = 6'd6,
        K_STA_DE   = 6'd7,
        K_STA_NN   = 6'd8,
        K_OUT_NA   = 6'd9,
        K_IN_AN    = 6'd10,
        K_IO_C     = 6'd11,
        K_CMP_UP   = 6'd12,
        K_CMP_DN   = 6'd13,
        K_CMPR_UP  = 6'd14,
        K_CMPR_DN  = 6'd15,
        K_COPY_R   = 6'd16,
        K_PIN_UP   = 6'd17,
        K_PIN_DN   = 6'd18,
        K_PINR_UP  = 6'd19,
        K_PINR_DN  = 6'd20,
        K_POUT_UP  = 6'd21,
        K_POUT_DN  = 6'd22,
        K_POUTR_UP = 6'd23,
        K_POUTR_DN = 6'd24,
        K_JP_WORD  = 6'd25,
        K_JR       = 6'd26,
        K_JR_CC    = 6'd27,
        K_DJNZ     = 6'd28,
        K_RET      = 6'd29,
        K_RET_CC   = 6'd30,
        K_RST      = 6'd31,
        K_HL_ARITH = 6'd32,
        K_IX_ADD   = 6'd33,
        K_NIB_ROT  = 6'd34,
        K_EX_STK   = 6'd35
    } ptr_cls_e;

endpackage

// File: rtl/sptr_block_rule.sv
// Pointer rules for the compare, block-copy and block port classes.
module sptr_block_rule
    import shadow_ptr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  ptr_cls_e              cls,
    input  logic [2*BYTE_W-1:0]   cur_ptr,
    input  logic [2*BYTE_W-1:0]   pc_init,
    input  logic [2*BYTE_W-1:0]   bc_pre,
    input  logic [2*BYTE_W-1:0]   bc_post,
    input  logic                  match,
    output logic                  upd,
    output logic [2*BYTE_W-1:0]   val,
    output logic                  b_live
);

    localparam int PTR_W = 2 * BYTE_W;
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    logic             c_live;
    logic [PTR_W-1:0] pc_step;

    assign c_live  = |bc_post;
    assign b_live  = |bc_post[PTR_W-1:BYTE_W];
    assign pc_step = pc_init + ONE;

    always_comb begin
        upd = 1'b0;
        val = cur_ptr;
        case (cls)
            K_CMP_UP: begin
                upd = 1'b1;
                val = cur_ptr + ONE;
            end
            K_CMP_DN: begin
                upd = 1'b1;
                val = cur_ptr - ONE;
            end
            K_CMPR_UP: begin
                upd = 1'b1;
                val = (c_live && !match) ? pc_step : cur_ptr + ONE;
            end
            K_CMPR_DN: begin
                upd = 1'b1;
                val = (c_live && !match) ? pc_step : cur_ptr - ONE;
            end
            K_COPY_R: begin
                upd = c_live;
                val = pc_step;
            end
            K_PIN_UP: begin
                upd = 1'b1;
                val = bc_pre + ONE;
            end
            K_PIN_DN: begin
                upd = 1'b1;
                val = bc_pre - ONE;
            end
            K_PINR_UP: begin
                upd = 1'b1;
                val = b_live ? pc_step : bc_pre + ONE;
            end
            K_PINR_DN: begin
                upd = 1'b1;
                val = b_live ? pc_step : bc_pre - ONE;
            end
            K_POUT_UP: begin
                upd = 1'b1;
                val = bc_post + ONE;
            end
            K_POUT_DN: begin
                upd = 1'b1;
                val = bc_post - ONE;
            end
            K_POUTR_UP: begin
                upd = 1'b1;
                val = b_live ? pc_step : bc_post + ONE;
            end
            K_POUTR_DN: begin
                upd = 1'b1;
                val = b_live ? pc_step : bc_post - ONE;
            end
            default: begin
                upd = 1'b0;
                val = cur_ptr;
            end
        endcase
    end

endmodule

// File: rtl/sptr_rule_calc.sv
// Selects the candidate pointer value for a retiring instruction class.
module sptr_rule_calc
    import shadow_ptr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  ptr_cls_e              cls,
    input  logic [2*BYTE_W-1:0]   cur_ptr,
    input  logic [2*BYTE_W-1:0]   pc_init,
    input  logic [2*BYTE_W-1:0]   pc_new,
    input  logic [2*BYTE_W-1:0]   bc_pre,
    input  logic [2*BYTE_W-1:0]   bc_post,
    input  logic [2*BYTE_W-1:0]   de,
    input  logic [2*BYTE_W-1:0]   hl,
    input  logic [2*BYTE_W-1:0]   idx,
    input  logic [BYTE_W-1:0]     acc,
    input  logic [BYTE_W-1:0]     imm8,
    input  logic [2*BYTE_W-1:0]   imm16,
    input  logic [BYTE_W-1:0]     disp,
    input  logic [2*BYTE_W-1:0]   stk,
    input  logic                  cond,
    input  logic                  match,
    output logic                  upd,
    output logic [2*BYTE_W-1:0]   val
);

    localparam int PTR_W = 2 * BYTE_W;
    localparam logic [PTR_W-1:0]  ONE    = PTR_W'(1);
    localparam logic [PTR_W-1:0]  TWO    = PTR_W'(2);
    localparam logic [BYTE_W-1:0] LO_ONE = BYTE_W'(1);

    logic             blk_upd;
    logic [PTR_W-1:0] blk_val;
    logic             b_live;
    logic [PTR_W-1:0] sdisp;
    logic [PTR_W-1:0] rel_tgt;

    assign sdisp   = {{(PTR_W-BYTE_W){disp[BYTE_W-1]}}, disp};
    assign rel_tgt = pc_init + TWO + sdisp;

    sptr_block_rule #(
        .BYTE_W (BYTE_W)
    ) u_block (
        .cls     (cls),
        .cur_ptr (cur_ptr),
        .pc_init (pc_init),
        .bc_pre  (bc_pre),
        .bc_post (bc_post),
        .match   (match),
        .upd     (blk_upd),
        .val     (blk_val),
        .b_live  (b_live)
    );

    always_comb begin
        upd = blk_upd;
        val = blk_val;
        case (cls)
            K_IDX_MEM: begin
                upd = 1'b1;
                val = idx + sdisp;
            end
            K_LDA_BC: begin
                upd = 1'b1;
                val = bc_pre + ONE;
            end
            K_LDA_DE: begin
                upd = 1'b1;
                val = de + ONE;
            end
            K_LDA_NN, K_LD16_NN: begin
                upd = 1'b1;
                val = imm16 + ONE;
            end
            K_STA_BC: begin
                upd = 1'b1;
                val = {acc, bc_pre[BYTE_W-1:0] + LO_ONE};
            end
            K_STA_DE: begin
                upd = 1'b1;
                val = {acc, de[BYTE_W-1:0] + LO_ONE};
            end
            K_STA_NN: begin
                upd = 1'b1;
                val = {acc, imm16[BYTE_W-1:0] + LO_ONE};
            end
            K_OUT_NA: begin
                upd = 1'b1;
                val = {acc, imm8 + LO_ONE};
            end
            K_IN_AN: begin
                upd = 1'b1;
                val = {acc, imm8} + ONE;
            end
            K_IO_C: begin
                upd = 1'b1;
                val = bc_pre + ONE;
            end
            K_JP_WORD: begin
                upd = 1'b1;
                val = imm16;
            end
            K_JR: begin
                upd = 1'b1;
                val = rel_tgt;
            end
            K_JR_CC: begin
                upd = cond;
                val = rel_tgt;
            end
            K_DJNZ: begin
                upd = b_live;
                val = rel_tgt;
            end
            K_RET, K_EX_STK: begin
                upd = 1'b1;
                val = stk;
            end
            K_RET_CC: begin
                upd = cond;
                val = stk;
            end
            K_RST: begin
                upd = 1'b1;
                val = pc_new;
            end
            K_HL_ARITH, K_NIB_ROT: begin
                upd = 1'b1;
                val = hl + ONE;
            end
            K_IX_ADD: begin
                upd = 1'b1;
                val = idx + ONE;
            end
            default: begin
                upd = blk_upd;
                val = blk_val;
            end
        endcase
    end

endmodule

// File: rtl/sptr_flag_leak.sv
// Places two pointer bits at their positions in the flag byte.
module sptr_flag_leak #(
    parameter int BYTE_W = 8,
    parameter int HI_DST = 5,
    parameter int LO_DST = 3
) (
    input  logic              src_hi,
    input  logic              src_lo,
    output logic [BYTE_W-1:0] flags
);

    always_comb begin
        flags         = '0;
        flags[HI_DST] = src_hi;
        flags[LO_DST] = src_lo;
    end

endmodule

// File: rtl/shadow_ptr_unit.sv
module shadow_ptr_unit
    import shadow_ptr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int HI_SRC = 13,
    parameter int LO_SRC = 11,
    parameter int HI_DST = 5,
    parameter int LO_DST = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done_i,
    input  logic [CLS_W-1:0]    cls_i,
    input  logic [2*BYTE_W-1:0] pc_init_i,
    input  logic [2*BYTE_W-1:0] pc_new_i,
    input  logic [2*BYTE_W-1:0] bc_pre_i,
    input  logic [2*BYTE_W-1:0] bc_post_i,
    input  logic [2*BYTE_W-1:0] de_i,
    input  logic [2*BYTE_W-1:0] hl_i,
    input  logic [2*BYTE_W-1:0] idx_i,
    input  logic [BYTE_W-1:0]   acc_i,
    input  logic [BYTE_W-1:0]   imm8_i,
    input  logic [2*BYTE_W-1:0] imm16_i,
    input  logic [BYTE_W-1:0]   disp_i,
    input  logic [2*BYTE_W-1:0] stk_i,
    input  logic                cond_i,
    input  logic                match_i,
    output logic [2*BYTE_W-1:0] ptr_o,
    output logic [BYTE_W-1:0]   flag_bits_o
);

    localparam int PTR_W = 2 * BYTE_W;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } sptr_state_t;

    sptr_state_t      st_d;
    sptr_state_t      st_q;
    logic             rule_upd;
    logic [PTR_W-1:0] rule_val;

    sptr_rule_calc #(
        .BYTE_W (BYTE_W)
    ) u_rules (
        .cls     (ptr_cls_e'(cls_i)),
        .cur_ptr (st_q.ptr),
        .pc_init (pc_init_i),
        .pc_new  (pc_new_i),
        .bc_pre  (bc_pre_i),
        .bc_post (bc_post_i),
        .de      (de_i),
        .hl      (hl_i),
        .idx     (idx_i),
        .acc     (acc_i),
        .imm8    (imm8_i),
        .imm16   (imm16_i),
        .disp    (disp_i),
        .stk     (stk_i),
        .cond    (cond_i),
        .match   (match_i),
        .upd     (rule_upd),
        .val     (rule_val)
    );

    always_comb begin
        st_d = st_q;
        if (done_i && rule_upd) begin
            st_d.ptr = rule_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o = st_q.ptr;

    sptr_flag_leak #(
        .BYTE_W (BYTE_W),
        .HI_DST (HI_DST),
        .LO_DST (LO_DST)
    ) u_leak (
        .src_hi (st_q.ptr[HI_SRC]),
        .src_lo (st_q.ptr[LO_SRC]),
        .flags  (flag_bits_o)
    );

endmodule

// File: rtl/shadow_ptr_checker.sv
module shadow_ptr_checker
    import shadow_ptr_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int FLG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done_i,
    input logic [CLS_W-1:0] cls_i,
    input logic [PTR_W-1:0] imm16_i,
    input logic [PTR_W-1:0] bc_post_i,
    input logic [PTR_W-1:0] ptr_o,
    input logic [FLG_W-1:0] flag_bits_o
);

    // R2: no strobe, no change
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(ptr_o));

    // R2: classes without a rule keep the pointer
    a_r2_unlisted_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && (cls_i == K_NONE || cls_i > K_EX_STK)) |=> $stable(ptr_o));

    // R7: single compare steps by one
    a_r7_cmp_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cls_i == K_CMP_UP) |=> ptr_o == $past(ptr_o) + PTR_W'(1));

    a_r7_cmp_dn_step: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cls_i == K_CMP_DN) |=> ptr_o == $past(ptr_o) - PTR_W'(1));

    // R8: finished block copy keeps the pointer
    a_r8_copy_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cls_i == K_COPY_R && bc_post_i == '0) |=> $stable(ptr_o));

    // R10: absolute jump or call lands on its word
    a_r10_jump_word: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cls_i == K_JP_WORD) |=> ptr_o == $past(imm16_i));

    // R13: flag fragment follows pointer bits 13 and 11
    a_r13_flag_leak: assert property (@(posedge clk) disable iff (!rst_n)
        flag_bits_o == {2'b00, ptr_o[13], 1'b0, ptr_o[11], 3'b000});

endmodule

bind shadow_ptr_unit shadow_ptr_checker #(
    .PTR_W (2*BYTE_W),
    .FLG_W (BYTE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_i      (done_i),
    .cls_i       (cls_i),
    .imm16_i     (imm16_i),
    .bc_post_i   (bc_post_i),
    .ptr_o       (ptr_o),
    .flag_bits_o (flag_bits_o)
);

// File: tb/shadow_ptr_unit_bench.sv
module shadow_ptr_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done_i = 1'b0;
    logic [5:0]  cls_i = '0;
    logic [15:0] pc_init_i, pc_new_i, bc_pre_i, bc_post_i, de_i, hl_i, idx_i;
    logic [7:0]  acc_i, imm8_i, disp_i;
    logic [15:0] imm16_i, stk_i;
    logic        cond_i = 1'b0;
    logic        match_i = 1'b0;
    logic [15:0] ptr_o;
    logic [7:0]  flag_bits_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    shadow_ptr_unit u_shadow_ptr_unit (
        .clk (clk), .rst_n (rst_n), .done_i (done_i), .cls_i (cls_i),
        .pc_init_i (pc_init_i), .pc_new_i (pc_new_i),
        .bc_pre_i (bc_pre_i), .bc_post_i (bc_post_i), .de_i (de_i),
        .hl_i (hl_i), .idx_i (idx_i), .acc_i (acc_i), .imm8_i (imm8_i),
        .imm16_i (imm16_i), .disp_i (disp_i), .stk_i (stk_i),
        .cond_i (cond_i), .match_i (match_i),
        .ptr_o (ptr_o), .flag_bits_o (flag_bits_o)
    );

    // {class, cond, match, expected pointer}
    localparam int NV = 43;
    localparam logic [23:0] VEC [NV] = '{
        {6'd1,  1'b0, 1'b0, 16'h4F80}, {6'd5,  1'b0, 1'b0, 16'h1300},
        {6'd2,  1'b0, 1'b0, 16'h2006}, {6'd4,  1'b0, 1'b0, 16'h1300},
        {6'd3,  1'b0, 1'b0, 16'h3100}, {6'd6,  1'b0, 1'b0, 16'hA706},
        {6'd7,  1'b0, 1'b0, 16'hA700}, {6'd12, 1'b0, 1'b0, 16'hA701},
        {6'd8,  1'b0, 1'b0, 16'hA700}, {6'd12, 1'b0, 1'b0, 16'hA701},
        {6'd9,  1'b0, 1'b0, 16'hA700}, {6'd10, 1'b0, 1'b0, 16'hA800},
        {6'd11, 1'b0, 1'b0, 16'h2006}, {6'd12, 1'b0, 1'b0, 16'h2007},
        {6'd13, 1'b0, 1'b0, 16'h2006}, {6'd14, 1'b0, 1'b0, 16'h1001},
        {6'd14, 1'b0, 1'b1, 16'h1002}, {6'd15, 1'b0, 1'b0, 16'h1001},
        {6'd15, 1'b0, 1'b1, 16'h1000}, {6'd16, 1'b0, 1'b0, 16'h1001},
        {6'd17, 1'b0, 1'b0, 16'h2006}, {6'd18, 1'b0, 1'b0, 16'h2004},
        {6'd19, 1'b0, 1'b0, 16'h1001}, {6'd21, 1'b0, 1'b0, 16'h2005},
        {6'd22, 1'b0, 1'b0, 16'h2003}, {6'd23, 1'b0, 1'b0, 16'h1001},
        {6'd22, 1'b0, 1'b0, 16'h2003}, {6'd24, 1'b0, 1'b0, 16'h1001},
        {6'd25, 1'b0, 1'b0, 16'h12FF}, {6'd26, 1'b0, 1'b0, 16'h0F82},
        {6'd29, 1'b0, 1'b0, 16'h6789}, {6'd27, 1'b0, 1'b0, 16'h6789},
        {6'd27, 1'b1, 1'b0, 16'h0F82}, {6'd30, 1'b0, 1'b0, 16'h0F82},
        {6'd30, 1'b1, 1'b0, 16'h6789}, {6'd31, 1'b0, 1'b0, 16'h0038},
        {6'd28, 1'b0, 1'b0, 16'h0F82}, {6'd32, 1'b0, 1'b0, 16'h4001},
        {6'd33, 1'b0, 1'b0, 16'h5001}, {6'd34, 1'b0, 1'b0, 16'h4001},
        {6'd35, 1'b0, 1'b0, 16'h6789}, {6'd0,  1'b0, 1'b0, 16'h6789},
        {6'd50, 1'b0, 1'b0, 16'h6789}
    };

    function automatic string req_of(input logic [5:0] c);
        if (c == 0 || c > 35) return "R2";
        if (c == 1)  return "R3";
        if (c <= 5)  return "R4";
        if (c <= 9)  return "R5";
        if (c <= 11) return "R6";
        if (c <= 15) return "R7";
        if (c == 16) return "R8";
        if (c <= 24) return "R9";
        if (c <= 28) return "R10";
        if (c <= 31) return "R11";
        return "R12";
    endfunction

    function automatic logic [7:0] flags_for(input logic [15:0] p);
        logic [7:0] f;
        f = 8'h00;
        f[5] = p[13];
        f[3] = p[11];
        return f;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic background();
        pc_init_i = 16'h1000; pc_new_i = 16'h0038;
        bc_pre_i  = 16'h2005; bc_post_i = 16'h2004;
        de_i = 16'h30FF; hl_i = 16'h4000; idx_i = 16'h5000;
        acc_i = 8'hA7; imm8_i = 8'hFF; imm16_i = 16'h12FF;
        disp_i = 8'h80; stk_i = 16'h6789;
        cond_i = 1'b0; match_i = 1'b0;
    endtask

    task automatic apply(input logic [5:0] c, input logic cd, input logic m);
        @(negedge clk);
        cls_i = c; cond_i = cd; match_i = m; done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        background();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", ptr_o, 16'h0000);
        chk("R1", {8'h00, flag_bits_o}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [5:0]  c;
            logic [15:0] e;
            c = VEC[i][23:18];
            e = VEC[i][15:0];
            apply(c, VEC[i][17], VEC[i][16]);
            chk(req_of(c), ptr_o, e);
            chk("R13", {8'h00, flag_bits_o}, {8'h00, flags_for(e)});
        end

        // R2 strobe low: jump class presented without completion
        @(negedge clk);
        cls_i = 6'd25; imm16_i = 16'hBEEF;
        @(negedge clk);
        @(negedge clk);
        chk("R2", ptr_o, 16'h6789);
        background();

        // R8 copy finished with BC zero keeps pointer
        bc_post_i = 16'h0000;
        apply(6'd16, 1'b0, 1'b0);
        chk("R8", ptr_o, 16'h6789);
        // R7 repeat compare with BC zero steps
        apply(6'd14, 1'b0, 1'b0);
        chk("R7", ptr_o, 16'h678A);
        apply(6'd15, 1'b0, 1'b0);
        chk("R7", ptr_o, 16'h6789);

        // R9 repeat port forms with B zero
        bc_post_i = 16'h00FF;
        apply(6'd19, 1'b0, 1'b0);
        chk("R9", ptr_o, 16'h2006);
        apply(6'd23, 1'b0, 1'b0);
        chk("R9", ptr_o, 16'h0100);
        apply(6'd20, 1'b0, 1'b0);
        chk("R9", ptr_o, 16'h2004);
        apply(6'd24, 1'b0, 1'b0);
        chk("R9", ptr_o, 16'h00FE);
        // R10 decrement-and-branch with B zero keeps pointer
        apply(6'd28, 1'b0, 1'b0);
        chk("R10", ptr_o, 16'h00FE);
        background();

        // R3 positive displacement wrapping past FFFFh
        idx_i = 16'hFFF0; disp_i = 8'h7F;
        apply(6'd1, 1'b0, 1'b0);
        chk("R3", ptr_o, 16'h006F);
        // R6 port read carries through all 16 bits
        acc_i = 8'hFF; imm8_i = 8'hFF;
        apply(6'd10, 1'b0, 1'b0);
        chk("R6", ptr_o, 16'h0000);
        // R5 store wraps low byte only
        acc_i = 8'h34; bc_pre_i = 16'h12FF;
        apply(6'd6, 1'b0, 1'b0);
        chk("R5", ptr_o, 16'h3400);
        background();

        // R13 flag positions
        imm16_i = 16'h2800;
        apply(6'd25, 1'b0, 1'b0);
        chk("R13", {8'h00, flag_bits_o}, 16'h0028);
        imm16_i = 16'h0800;
        apply(6'd25, 1'b0, 1'b0);
        chk("R13", {8'h00, flag_bits_o}, 16'h0008);
        imm16_i = 16'hD7FF;
        apply(6'd25, 1'b0, 1'b0);
        chk("R13", {8'h00, flag_bits_o}, 16'h0000);
        imm16_i = 16'h2000;
        apply(6'd25, 1'b0, 1'b0);
        chk("R13", {8'h00, flag_bits_o}, 16'h0020);

        // R1 reset during operation
        imm16_i = 16'h1234;
        apply(6'd25, 1'b0, 1'b0);
        chk("R10", ptr_o, 16'h1234);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", ptr_o, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule